// File: doc/BRIEF.md
# Packed int8 dual-lane multiply-accumulate element

This block is one cell of a weight-stationary systolic array working in int8 mode. Each 16-bit input word carries two signed bytes that sit next to each other along the dot-product (contracting) dimension. Every accepted cycle, the cell multiplies both activation bytes by the matching bytes of its stationary weight word, using two signed multipliers in parallel. One three-operand adder then sums the two 16-bit products and the int32 partial sum arriving from the cell above. Because two products retire per cycle instead of one, the cell delivers twice the int8 rate of a single-multiplier cell.

The activation word is forwarded to the right-hand neighbour one cycle later, and the new partial sum leaves downward one cycle later with a valid flag. A column of cells chained through their partial-sum ports, fed with activations skewed by one cycle per row, computes a dot product of length twice the column height. Weights go into a shadow register through a load port and become active only on a swap pulse, so the next tile can be preloaded while the current one streams.

The streaming interfaces carry a valid flag and no ready: the array advances in lockstep and there is no back-pressure. A beat presented with its valid high is always consumed in that cycle, and the partial-sum input is taken to belong to the same beat as the activation word that arrives with it. The accumulator wraps modulo 2^32 and does not saturate.

Top module: `sdp_pe`

## Requirements
- R1: After reset, `psum_o` and `act_o` are zero, `psum_valid_o` and `act_valid_o` are low, and the active weight is zero, so a beat sent before any swap returns its `psum_i` unchanged.
- R2: Each lane is a signed two's-complement byte product. The low activation byte (bits 7:0) is multiplied by the low weight byte (bits 7:0), and the high activation byte (bits 15:8) is multiplied by the high weight byte (bits 15:8).
- R3: One cycle after a beat with `act_valid_i` high, `psum_o` equals `psum_i` plus both lane products. The sum wraps modulo 2^32, with no saturation.
- R4: `psum_valid_o` is `act_valid_i` delayed by one cycle. In a cycle after `act_valid_i` was low, `psum_o` keeps its previous value.
- R5: The change from `psum_i` to `psum_o` for one beat lies within [-32512, +32768]. The upper bound is reached when all four bytes are 0x80.
- R6: `act_o` and `act_valid_o` repeat `act_i` and `act_valid_i` one cycle later. `act_o` holds its value when no beat was accepted.
- R7: A pulse on `wgt_load_i` writes `wgt_i` into the shadow register and does not change the weight used by beats. Only a pulse on `wgt_swap_i` copies the shadow into the active weight, which takes effect from the next cycle.
- R8: When load and swap occur in the same cycle, the active weight takes the previous shadow contents and the shadow takes the new word.
- R9: A column of chained cells, with row j fed one cycle after row j-1 and a zero partial sum at the top, produces at its bottom the full signed dot product of all packed activation bytes with the column's weight bytes, one result per beat and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_valid_i | input | 1 | Activation and partial-sum beat present |
| act_i | input | 16 | Two packed signed activation bytes |
| psum_i | input | 32 | Incoming partial sum from the cell above |
| wgt_load_i | input | 1 | Write `wgt_i` into the shadow weight register |
| wgt_i | input | 16 | Two packed signed weight bytes |
| wgt_swap_i | input | 1 | Copy the shadow weight into the active weight |
| act_valid_o | output | 1 | Forwarded beat valid |
| act_o | output | 16 | Forwarded activation word to the right neighbour |
| psum_valid_o | output | 1 | Outgoing partial sum valid |
| psum_o | output | 32 | Outgoing partial sum to the cell below |

## Verification
On every cycle, the assertions check the one-cycle forwarding of the activation word and its valid flag, the hold of the outputs after idle cycles, the bound on the per-beat increment, and the rule that the active weight changes only on a swap and then takes the shadow contents. The exact lane pairing, signed byte handling, wraparound of the accumulator, the load-with-swap ordering and the full skewed column dot product are value questions that only the bench's scenarios, compared against a software dot product, can show.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  localparam int unsigned SDP_LANE_W = 8;
  localparam int unsigned SDP_LANES  = 2;
  localparam int unsigned SDP_ACC_W  = 32;

  // Largest positive product of two signed w-bit values: (-2^(w-1))^2
  function automatic int sdp_max_prod(input int unsigned w);
    return (1 << (w - 1)) * (1 << (w - 1));
  endfunction

  // Most negative product of two signed w-bit values: -2^(w-1) * (2^(w-1)-1)
  function automatic int sdp_min_prod(input int unsigned w);
    return -((1 << (w - 1)) * ((1 << (w - 1)) - 1));
  endfunction

endpackage

// File: rtl/sdp_lane_mul.sv
module sdp_lane_mul #(
  parameter int unsigned W = 8
) (
  input  logic signed [W-1:0]   a_i,
  input  logic signed [W-1:0]   b_i,
  output logic signed [2*W-1:0] prod_o
);

  always_comb begin
    prod_o = a_i * b_i;
  end

endmodule

// File: rtl/sdp_weight_bank.sv
module sdp_weight_bank #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              swap_i,
  output logic [WORD_W-1:0] active_o
);

  logic [WORD_W-1:0] shadow_q;
  logic [WORD_W-1:0] active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (load_i) begin
      shadow_q <= data_i;
    end
  end

  // Swap takes the shadow value present before this edge's load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (swap_i) begin
      active_q <= shadow_q;
    end
  end

  assign active_o = active_q;

  AST_SWAP_TAKES_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    swap_i |=> active_q == $past(shadow_q)); // R8

  AST_ACTIVE_ONLY_ON_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_i |=> $stable(active_q)); // R7

endmodule

// File: rtl/sdp_sum3.sv
module sdp_sum3 #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned PROD_W = 16,
  parameter int unsigned ACC_W  = 32
) (
  input  logic [LANES-1:0][PROD_W-1:0] prod_i,
  input  logic [ACC_W-1:0]             psum_i,
  output logic [ACC_W-1:0]             sum_o
);

  localparam int unsigned EXT_W = ACC_W - PROD_W;

  logic [LANES-1:0][ACC_W-1:0] ext;

  for (genvar l = 0; l < LANES; l++) begin : g_ext
    assign ext[l] = {{EXT_W{prod_i[l][PROD_W-1]}}, prod_i[l]};
  end

  // With two lanes this is a single three-operand sum
  always_comb begin
    sum_o = psum_i;
    for (int l = 0; l < LANES; l++) begin
      sum_o = sum_o + ext[l];
    end
  end

endmodule

// File: rtl/sdp_pe.sv
module sdp_pe
  import sdp_pkg::*;
#(
  parameter int unsigned LANE_W = SDP_LANE_W,
  parameter int unsigned LANES  = SDP_LANES,
  parameter int unsigned ACC_W  = SDP_ACC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    act_valid_i,
  input  logic [LANES*LANE_W-1:0] act_i,
  input  logic [ACC_W-1:0]        psum_i,
  input  logic                    wgt_load_i,
  input  logic [LANES*LANE_W-1:0] wgt_i,
  input  logic                    wgt_swap_i,
  output logic                    act_valid_o,
  output logic [LANES*LANE_W-1:0] act_o,
  output logic                    psum_valid_o,
  output logic [ACC_W-1:0]        psum_o
);

  localparam int unsigned WORD_W = LANES * LANE_W;
  localparam int unsigned PROD_W = 2 * LANE_W;
  localparam int          INC_HI = int'(LANES) * sdp_max_prod(LANE_W);
  localparam int          INC_LO = int'(LANES) * sdp_min_prod(LANE_W);

  logic [WORD_W-1:0]             wgt_active;
  logic [LANES-1:0][PROD_W-1:0]  prod;
  logic [ACC_W-1:0]              sum_next;

  logic                          act_valid_q;
  logic [WORD_W-1:0]             act_q;
  logic                          psum_valid_q;
  logic [ACC_W-1:0]              psum_q;

  sdp_weight_bank #(
    .WORD_W (WORD_W)
  ) u_wbank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (wgt_load_i),
    .data_i   (wgt_i),
    .swap_i   (wgt_swap_i),
    .active_o (wgt_active)
  );

  // Lane l pairs activation byte l with weight byte l
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [PROD_W-1:0] lane_prod;

    sdp_lane_mul #(
      .W (LANE_W)
    ) u_mul (
      .a_i    (act_i[l*LANE_W +: LANE_W]),
      .b_i    (wgt_active[l*LANE_W +: LANE_W]),
      .prod_o (lane_prod)
    );

    assign prod[l] = lane_prod;
  end

  sdp_sum3 #(
    .LANES  (LANES),
    .PROD_W (PROD_W),
    .ACC_W  (ACC_W)
  ) u_sum (
    .prod_i (prod),
    .psum_i (psum_i),
    .sum_o  (sum_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_valid_q  <= 1'b0;
      psum_valid_q <= 1'b0;
    end else begin
      act_valid_q  <= act_valid_i;
      psum_valid_q <= act_valid_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      psum_q <= '0;
    end else if (act_valid_i) begin
      act_q  <= act_i;
      psum_q <= sum_next;
    end
  end

  assign act_valid_o  = act_valid_q;
  assign act_o        = act_q;
  assign psum_valid_o = psum_valid_q;
  assign psum_o       = psum_q;

  AST_ACT_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid_i |=> (act_valid_o && act_o == $past(act_i))); // R6

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !act_valid_i |=> (!act_valid_o && $stable(act_o))); // R6

  AST_PSUM_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid_i |=> psum_valid_o); // R4

  AST_PSUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !act_valid_i |=> (!psum_valid_o && $stable(psum_o))); // R4

  AST_INC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid_i |=> ($signed(psum_o - $past(psum_i)) <= INC_HI &&
                     $signed(psum_o - $past(psum_i)) >= INC_LO)); // R5

endmodule

// File: tb/test_sdp_pe.sv
`timescale 1ns/1ps
module test_sdp_pe;

  localparam int COLN = 4;
  localparam int CM   = 6;
  localparam int NV   = 8;

  // {act[63:48], wgt[47:32], psum[31:0]}
  localparam logic [63:0] VEC [NV] = '{
    {16'h0302, 16'h0504, 32'h0000_0000},
    {16'hFF01, 16'h0102, 32'h0000_0064},
    {16'h8080, 16'h7F7F, 32'hFFFF_FFFB},
    {16'h7F80, 16'h807F, 32'h0000_03E8},
    {16'h0000, 16'hFFFF, 32'h0000_3039},
    {16'h8101, 16'h01FF, 32'h8000_0000},
    {16'h7F7F, 16'h7F7F, 32'h0000_0000},
    {16'hFE02, 16'hFD03, 32'hFFFF_FC18}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic        av, wl, ws;
  logic [15:0] a, w;
  logic [31:0] ps;
  logic        avo, pvo;
  logic [15:0] ao;
  logic [31:0] po;

  sdp_pe i_sdp_pe (
    .clk(clk), .rst_n(rst_n), .act_valid_i(av), .act_i(a), .psum_i(ps),
    .wgt_load_i(wl), .wgt_i(w), .wgt_swap_i(ws), .act_valid_o(avo),
    .act_o(ao), .psum_valid_o(pvo), .psum_o(po)
  );

  // Column of chained elements
  logic        c_av [COLN];
  logic [15:0] c_a  [COLN];
  logic [15:0] c_w  [COLN];
  logic        c_wl, c_ws;
  logic [31:0] c_chain [COLN+1];
  logic        c_avo [COLN];
  logic [15:0] c_ao  [COLN];
  logic        c_pv  [COLN];

  assign c_chain[0] = '0;

  for (genvar j = 0; j < COLN; j++) begin : g_col
    sdp_pe u_pe (
      .clk(clk), .rst_n(rst_n), .act_valid_i(c_av[j]), .act_i(c_a[j]),
      .psum_i(c_chain[j]), .wgt_load_i(c_wl), .wgt_i(c_w[j]),
      .wgt_swap_i(c_ws), .act_valid_o(c_avo[j]), .act_o(c_ao[j]),
      .psum_valid_o(c_pv[j]), .psum_o(c_chain[j+1])
    );
  end

  function automatic logic [31:0] ref_step(logic [31:0] p, logic [15:0] ac, logic [15:0] wg);
    int r;
    r = int'(p);
    r = r + int'($signed(ac[7:0])) * int'($signed(wg[7:0]));
    r = r + int'($signed(ac[15:8])) * int'($signed(wg[15:8]));
    return 32'(r);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_swap(logic [15:0] wv);
    @(negedge clk); wl = 1'b1; w = wv;
    @(negedge clk); wl = 1'b0; ws = 1'b1;
    @(negedge clk); ws = 1'b0;
  endtask

  task automatic beat(logic [15:0] av_, logic [31:0] ps_);
    av = 1'b1; a = av_; ps = ps_;
    @(negedge clk); av = 1'b0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  logic [7:0]  cwb [2*COLN];
  logic [7:0]  cab [CM][2*COLN];
  int          cexp [CM];
  logic [31:0] seed;

  initial begin
    av = 0; wl = 0; ws = 0; a = '0; w = '0; ps = '0;
    c_wl = 0; c_ws = 0;
    for (int j = 0; j < COLN; j++) begin c_av[j] = 0; c_a[j] = '0; c_w[j] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 psum_o", po, 32'h0);
    chk("R1 act_o", {16'h0, ao}, 32'h0);
    chk("R1 valids", {30'h0, avo, pvo}, 32'h0);
    beat(16'h7F81, 32'h0000_1234);
    chk("R1 zero active weight", po, 32'h0000_1234);

    // Table walk: R2 lane pairing, R3 sum and wrap, R6 forwarding
    for (int i = 0; i < NV; i++) begin
      load_swap(VEC[i][47:32]);
      beat(VEC[i][63:48], VEC[i][31:0]);
      chk("R3 psum_o", po, ref_step(VEC[i][31:0], VEC[i][63:48], VEC[i][47:32]));
      chk("R6 act_o", {16'h0, ao}, {16'h0, VEC[i][63:48]});
      chk("R4 psum_valid_o", {31'h0, pvo}, 32'h1);
    end

    // R2 lanes are not crossed: only low lane nonzero
    load_swap(16'h0003);
    beat(16'h0502, 32'h0);
    chk("R2 low lane pairing", po, 32'd6);

    // R4 and R6 hold on idle cycle
    @(negedge clk);
    chk("R4 hold psum_o", po, 32'd6);
    chk("R4 valid low", {31'h0, pvo}, 32'h0);
    chk("R6 hold act_o", {16'h0, ao}, 32'h0502);
    chk("R6 act_valid low", {31'h0, avo}, 32'h0);

    // R5 maximum increment
    load_swap(16'h8080);
    beat(16'h8080, 32'd10);
    chk("R5 max increment", po, 32'd32778);

    // R3 wrap at the top of the int32 range
    load_swap(16'h7F7F);
    beat(16'h7F7F, 32'h7FFF_FFFF);
    chk("R3 wraparound", po, 32'h7FFF_FFFF + 32'd32258);

    // R7 load without swap leaves active weight
    load_swap(16'h0101);
    @(negedge clk); wl = 1'b1; w = 16'h0909;
    @(negedge clk); wl = 1'b0;
    beat(16'h0203, 32'h0);
    chk("R7 load without swap", po, 32'd5);
    @(negedge clk); ws = 1'b1;
    @(negedge clk); ws = 1'b0;
    beat(16'h0203, 32'h0);
    chk("R7 swap activates shadow", po, 32'd45);

    // R8 load and swap in the same cycle
    @(negedge clk); wl = 1'b1; w = 16'h0202; ws = 1'b1;   // active <- 0x0909
    @(negedge clk); wl = 1'b0; ws = 1'b0;
    beat(16'h0101, 32'h0);
    chk("R8 swap takes old shadow", po, 32'd18);
    @(negedge clk); ws = 1'b1;
    @(negedge clk); ws = 1'b0;
    beat(16'h0101, 32'h0);
    chk("R8 shadow kept new word", po, 32'd4);

    // R9 skewed column dot product
    seed = 32'h1357_9BDF;
    for (int k = 0; k < 2*COLN; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      cwb[k] = seed[23:16];
    end
    cwb[0] = 8'h80; cwb[3] = 8'h80;
    for (int m = 0; m < CM; m++) begin
      cexp[m] = 0;
      for (int k = 0; k < 2*COLN; k++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        cab[m][k] = seed[23:16];
      end
    end
    cab[0][0] = 8'h80; cab[1][3] = 8'h80; cab[2][7] = 8'h80;
    for (int m = 0; m < CM; m++)
      for (int k = 0; k < 2*COLN; k++)
        cexp[m] += int'($signed(cab[m][k])) * int'($signed(cwb[k]));

    @(negedge clk);
    c_wl = 1'b1;
    for (int j = 0; j < COLN; j++) c_w[j] = {cwb[2*j+1], cwb[2*j]};
    @(negedge clk); c_wl = 1'b0; c_ws = 1'b1;
    @(negedge clk); c_ws = 1'b0;

    begin
      int nout;
      nout = 0;
      for (int c = 0; c < CM + COLN + 2; c++) begin
        if (c_pv[COLN-1]) begin
          if (nout < CM) chk("R9 column result", c_chain[COLN], 32'(cexp[nout]));
          nout++;
        end
        for (int j = 0; j < COLN; j++) begin
          if (c - j >= 0 && c - j < CM) begin
            c_av[j] = 1'b1;
            c_a[j]  = {cab[c-j][2*j+1], cab[c-j][2*j]};
          end else begin
            c_av[j] = 1'b0;
          end
        end
        @(negedge clk);
      end
      chk("R9 result count", 32'(nout), 32'(CM));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule